// File: doc/BRIEF.md
# Four-Channel Pulse Width Modulator with Period-Boundary Updates

This block is a PWM peripheral on a simple 32-bit register bus. It drives one output pin for each of four independent channels. Every channel has its own counter, a programmable clock prescaler, a polarity control, and 16-bit period and duty values. A running channel is never reprogrammed in mid-period. New duty or period values are first parked in update registers. They move into the working registers only when the channel counter completes a period.

The duty value sets where the active part of the period begins, not how long it lasts. The counter runs from 0 to period-1, and the output is active from the count equal to the duty value up to the end of the period. Software that wants A active ticks therefore writes period minus A. Channels are switched on and off through write-one-to-act enable and disable registers, and a read-only status register shows which channels run. All registers are read combinationally from the address bus. A write takes one clock.

Top module: `pwm4_ctrl`

## Requirements
- R1: After reset every channel is disabled, every output is low, and the status, mode, duty, period and update registers all read zero.
- R2: Writing 1 to bit n at offset 0x04 enables channel n and writing 1 to bit n at offset 0x08 disables it. Zero bits have no effect. Offset 0x0C reads the enabled channels in bits [3:0], and writes to it are ignored.
- R3: Channel n's registers sit at 0x200 + n*0x20. Mode bits [3:0] = N make the counter advance once every 2^N clocks of a free-running prescaler that starts at reset. An N above 10 acts as 10.
- R4: A running channel counts 0 to period-1 and wraps. Its output is at the active level while the count is at or above duty and the period is nonzero. A period of 0 keeps the output at the inactive level.
- R5: Mode bit 9 set inverts the output: the active level becomes 0 and the inactive level, including the level of a disabled channel, becomes 1.
- R6: Duty (+0x04), duty update (+0x08), period (+0x0C) and period update (+0x10) keep only data bits [15:0], and their bits [31:16] read zero. The mode register (+0x00) reads back only bits [3:0] and bit 9.
- R7: Writes to duty or period take effect at once while the channel is disabled. While the channel is enabled they are ignored.
- R8: A write to duty update or period update stores the value, and it reads back at once. A pending value is copied into the working register on the tick where the counter wraps from period-1 to 0, or on any tick while the period is 0. A running channel's working value is unchanged until that tick.
- R9: Disabling a channel clears its counter and puts its output at the inactive level. Enabling a stopped channel restarts its counter from 0.
- R10: Reads of unmapped offsets, including the enable and disable registers, return zero. Writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the current address and data |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| pwmOut | output | 4 | Channel outputs, bit n for channel n |

## Verification
The hardest case to reach from the ports is a buffered value landing on a period boundary. The write must arrive while the channel runs, and its effect appears only on a later tick, whose timing depends on the prescaler phase since reset. The bench uses a behavioural model that tracks the prescaler, counters and pending flags on every clock. It drives update writes at arbitrary phases and compares every output on every cycle. It also forces the prescaler clamp case with a long period that spans thousands of clocks, and the zero-period case where the only boundary is a bare tick.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int NUM_CH   = 4;
  localparam int CNT_W    = 16;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int PRES_W   = 4;
  localparam int MAX_PRES = 10;

  // write strobes from the register decoder to the channel datapath
  typedef struct packed {
    logic [NUM_CH-1:0] enSet;
    logic [NUM_CH-1:0] enClr;
    logic [NUM_CH-1:0] modeWr;
    logic [NUM_CH-1:0] dtyWr;
    logic [NUM_CH-1:0] dtyUpdWr;
    logic [NUM_CH-1:0] prdWr;
    logic [NUM_CH-1:0] prdUpdWr;
    logic [DATA_W-1:0] wdata;
  } strobe_t;

  // per-channel state visible to the read path
  typedef struct packed {
    logic              en;
    logic              pol;
    logic [PRES_W-1:0] pres;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  dty;
    logic [CNT_W-1:0]  dtyUpd;
    logic [CNT_W-1:0]  prd;
    logic [CNT_W-1:0]  prdUpd;
  } chView_t;
endpackage

// File: rtl/pwm4_regctl.sv
module pwm4_regctl
  import pwm4_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ENA_OFF   = 12'h004,
  parameter logic [ADDR_W-1:0] DIS_OFF   = 12'h008,
  parameter logic [ADDR_W-1:0] STAT_OFF  = 12'h00C,
  parameter logic [ADDR_W-1:0] BANK_BASE = 12'h200,
  parameter int                BANK_SZ   = 32
) (
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  chView_t [NUM_CH-1:0] chView,
  output strobe_t              strobe,
  output logic [DATA_W-1:0]    rdata
);
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int OFF_W   = $clog2(BANK_SZ);
  localparam int SPAN    = NUM_CH * BANK_SZ;
  localparam int MODE_POL_BIT = 9;

  logic [ADDR_W-1:0] bankRel;
  logic              inBank;
  logic [CH_W-1:0]   chIdx;
  logic [OFF_W-1:0]  regOff;
  logic              selMode, selDty, selDtyUpd, selPrd, selPrdUpd;

  assign bankRel = addr - BANK_BASE;
  assign inBank  = (addr >= BANK_BASE) && (bankRel < ADDR_W'(SPAN)) && (addr[1:0] == 2'b00);
  assign chIdx   = bankRel[OFF_W +: CH_W];
  assign regOff  = bankRel[OFF_W-1:0];

  assign selMode   = inBank && (regOff == OFF_W'(8'h00));
  assign selDty    = inBank && (regOff == OFF_W'(8'h04));
  assign selDtyUpd = inBank && (regOff == OFF_W'(8'h08));
  assign selPrd    = inBank && (regOff == OFF_W'(8'h0C));
  assign selPrdUpd = inBank && (regOff == OFF_W'(8'h10));

  assign strobe.wdata = wdata;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_strb
    logic hit;
    assign hit = wrEn && (chIdx == CH_W'(i));
    assign strobe.enSet[i]    = wrEn && (addr == ENA_OFF) && wdata[i];
    assign strobe.enClr[i]    = wrEn && (addr == DIS_OFF) && wdata[i];
    assign strobe.modeWr[i]   = hit && selMode;
    assign strobe.dtyWr[i]    = hit && selDty;
    assign strobe.dtyUpdWr[i] = hit && selDtyUpd;
    assign strobe.prdWr[i]    = hit && selPrd;
    assign strobe.prdUpdWr[i] = hit && selPrdUpd;
  end

  logic [NUM_CH-1:0] enVec;
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) enVec[i] = chView[i].en;
  end

  always_comb begin
    rdata = '0;
    if (addr == STAT_OFF) begin
      rdata[NUM_CH-1:0] = enVec;
    end else if (selMode) begin
      rdata[PRES_W-1:0]   = chView[chIdx].pres;
      rdata[MODE_POL_BIT] = chView[chIdx].pol;
    end else if (selDty) begin
      rdata[CNT_W-1:0] = chView[chIdx].dty;
    end else if (selDtyUpd) begin
      rdata[CNT_W-1:0] = chView[chIdx].dtyUpd;
    end else if (selPrd) begin
      rdata[CNT_W-1:0] = chView[chIdx].prd;
    end else if (selPrdUpd) begin
      rdata[CNT_W-1:0] = chView[chIdx].prdUpd;
    end
  end
endmodule

// File: rtl/pwm4_datapath.sv
module pwm4_datapath
  import pwm4_pkg::*;
#(
  parameter int MODE_POL_BIT = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  output chView_t [NUM_CH-1:0] chView,
  output logic [NUM_CH-1:0]    pwmOut
);
  // free-running prescaler shared by all channels
  logic [MAX_PRES-1:0] preCnt;
  logic [MAX_PRES:0]   tickVec;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign tickVec[0] = 1'b1;
  for (genvar k = 1; k <= MAX_PRES; k++) begin : g_tick
    assign tickVec[k] = &preCnt[k-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              en, pol, pendDty, pendPrd;
    logic [PRES_W-1:0] pres, presEff;
    logic [CNT_W-1:0]  cnt, dty, dtyUpd, prd, prdUpd;
    logic              tick, prdZero, atEnd, boundary, active;

    assign presEff  = (pres > PRES_W'(MAX_PRES)) ? PRES_W'(MAX_PRES) : pres;
    assign tick     = tickVec[presEff];
    assign prdZero  = (prd == '0);
    assign atEnd    = !prdZero && (cnt == prd - CNT_W'(1));
    assign boundary = prdZero || atEnd;
    assign active   = en && !prdZero && (cnt >= dty);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        en <= 1'b0; pol <= 1'b0; pres <= '0; cnt <= '0;
        dty <= '0; dtyUpd <= '0; prd <= '0; prdUpd <= '0;
        pendDty <= 1'b0; pendPrd <= 1'b0;
      end else begin
        // run control
        if (strobe.enClr[i]) begin
          en  <= 1'b0;
          cnt <= '0;
        end else if (strobe.enSet[i] && !en) begin
          en  <= 1'b1;
          cnt <= '0;
        end else if (en && tick) begin
          if (!prdZero) cnt <= atEnd ? '0 : cnt + CNT_W'(1);
          if (boundary) begin
            if (pendDty) begin dty <= dtyUpd; pendDty <= 1'b0; end
            if (pendPrd) begin prd <= prdUpd; pendPrd <= 1'b0; end
          end
        end
        // register writes; a same-cycle update write re-arms the pending flag
        if (strobe.modeWr[i]) begin
          pres <= strobe.wdata[PRES_W-1:0];
          pol  <= strobe.wdata[MODE_POL_BIT];
        end
        if (strobe.dtyWr[i] && !en) dty <= strobe.wdata[CNT_W-1:0];
        if (strobe.prdWr[i] && !en) prd <= strobe.wdata[CNT_W-1:0];
        if (strobe.dtyUpdWr[i]) begin
          dtyUpd  <= strobe.wdata[CNT_W-1:0];
          pendDty <= 1'b1;
        end
        if (strobe.prdUpdWr[i]) begin
          prdUpd  <= strobe.wdata[CNT_W-1:0];
          pendPrd <= 1'b1;
        end
      end
    end

    assign pwmOut[i] = active ^ pol;

    assign chView[i].en     = en;
    assign chView[i].pol    = pol;
    assign chView[i].pres   = pres;
    assign chView[i].cnt    = cnt;
    assign chView[i].dty    = dty;
    assign chView[i].dtyUpd = dtyUpd;
    assign chView[i].prd    = prd;
    assign chView[i].prdUpd = prdUpd;
  end
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] pwmOut
);
  strobe_t              strobe;
  chView_t [NUM_CH-1:0] chView;

  pwm4_regctl u_regctl (
    .wrEn   (wrEn),
    .addr   (addr),
    .wdata  (wdata),
    .chView (chView),
    .strobe (strobe),
    .rdata  (rdata)
  );

  pwm4_datapath u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .chView (chView),
    .pwmOut (pwmOut)
  );
endmodule

// File: rtl/pwm4_ctrl_chk.sv
module pwm4_ctrl_chk
  import pwm4_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic [NUM_CH-1:0]    pwmOut,
  input chView_t [NUM_CH-1:0] chRegs
);
  logic [NUM_CH-1:0] enVec;
  logic              bankWordRd;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) enVec[i] = chRegs[i].en;
  end

  assign bankWordRd = (addr >= 12'h200) && (addr < 12'h280) &&
                      ((addr[4:0] == 5'h04) || (addr[4:0] == 5'h08) ||
                       (addr[4:0] == 5'h0C) || (addr[4:0] == 5'h10));

  AST_STATUS_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 12'h00C) |-> (rdata == DATA_W'(enVec))) else $error("status mismatch"); // R2

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    bankWordRd |-> (rdata[DATA_W-1:CNT_W] == '0)) else $error("upper bits set"); // R6

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
    AST_CNT_BELOW_PRD: assert property (@(posedge clk) disable iff (!rstN)
      (chRegs[i].en && chRegs[i].prd != '0) |-> (chRegs[i].cnt < chRegs[i].prd)) else $error("count overrun"); // R4

    AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
      !chRegs[i].en |-> (pwmOut[i] == chRegs[i].pol)) else $error("stopped output not inactive"); // R9

    AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == 12'h008 && wdata[i]) |=> (!chRegs[i].en && chRegs[i].cnt == '0)) else $error("disable failed"); // R9

    AST_EN_RESTART: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == 12'h004 && wdata[i] && !chRegs[i].en) |=> (chRegs[i].en && chRegs[i].cnt == '0)) else $error("enable failed"); // R2

    AST_RUN_PRD_HELD: assert property (@(posedge clk) disable iff (!rstN)
      (chRegs[i].en && $past(chRegs[i].en) && chRegs[i].cnt != '0 && $past(chRegs[i].cnt) != '0)
        |-> $stable(chRegs[i].prd)) else $error("period changed mid-period"); // R8
  end
endmodule

bind pwm4_ctrl pwm4_ctrl_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .pwmOut (pwmOut),
  .chRegs (chView)
);

// File: tb/pwm4_ctrl_tb.sv
`timescale 1ns/1ps
module pwm4_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwmOut;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm4_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwmOut(pwmOut)
  );

  // behavioural reference state
  int mEn[4], mCnt[4], mPrd[4], mDty[4], mPrdU[4], mDtyU[4];
  int mPendP[4], mPendD[4], mPres[4], mPol[4];
  int mPre;

  function automatic int modelOut(int c);
    int act;
    act = (mEn[c] != 0 && mPrd[c] != 0 && mCnt[c] >= mDty[c]) ? 1 : 0;
    return act ^ mPol[c];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin
        mEn[c] = 0; mCnt[c] = 0; mPrd[c] = 0; mDty[c] = 0; mPrdU[c] = 0;
        mDtyU[c] = 0; mPendP[c] = 0; mPendD[c] = 0; mPres[c] = 0; mPol[c] = 0;
      end
      mPre = 0;
    end else begin
      int a, rel, bc, ro, w;
      bit bankOk;
      a = int'(addr);
      w = int'(wdata[15:0]);
      bankOk = wrEn && a >= 'h200 && a < 'h280 && (a % 4) == 0;
      rel = a - 'h200;
      bc = rel / 32;
      ro = rel % 32;
      for (int c = 0; c < 4; c++) begin
        int n, oldEn;
        bit tk, bnd;
        n = (mPres[c] > 10) ? 10 : mPres[c];
        tk = ((mPre % (1 << n)) == ((1 << n) - 1));
        oldEn = mEn[c];
        if (wrEn && a == 'h008 && wdata[c]) begin
          mEn[c] = 0; mCnt[c] = 0;
        end else if (wrEn && a == 'h004 && wdata[c] && oldEn == 0) begin
          mEn[c] = 1; mCnt[c] = 0;
        end else if (oldEn != 0 && tk) begin
          bnd = (mPrd[c] == 0) || (mCnt[c] == mPrd[c] - 1);
          if (mPrd[c] != 0) mCnt[c] = bnd ? 0 : mCnt[c] + 1;
          if (bnd) begin
            if (mPendD[c] != 0) begin mDty[c] = mDtyU[c]; mPendD[c] = 0; end
            if (mPendP[c] != 0) begin mPrd[c] = mPrdU[c]; mPendP[c] = 0; end
          end
        end
        if (bankOk && bc == c) begin
          case (ro)
            'h00: begin mPres[c] = int'(wdata[3:0]); mPol[c] = int'(wdata[9]); end
            'h04: if (oldEn == 0) mDty[c] = w;
            'h08: begin mDtyU[c] = w; mPendD[c] = 1; end
            'h0C: if (oldEn == 0) mPrd[c] = w;
            'h10: begin mPrdU[c] = w; mPendP[c] = 1; end
            default: ;
          endcase
        end
      end
      mPre = (mPre + 1) % 1024;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-cycle waveform comparison against the reference (R4, R5, R9)
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int c = 0; c < 4; c++) begin
        nChk++;
        if (int'(pwmOut[c]) != modelOut(c)) begin
          nFail++;
          $display("FAIL R4 waveform ch%0d actual=%0d expected=%0d", c, pwmOut[c], modelOut(c));
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rdChk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(rdata == exp, req, rdata, exp);
    addr = '0;
  endtask

  task automatic highCount(input int c, input int n, output int hc);
    hc = 0;
    repeat (n) begin
      @(negedge clk);
      hc += int'(pwmOut[c]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int hc;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk(12'h00C, 32'h0, "R1 status");
    check(pwmOut == 4'h0, "R1 outputs", 32'(pwmOut), 32'h0);
    rdChk(12'h200, 32'h0, "R1 mode");
    rdChk(12'h204, 32'h0, "R1 duty");
    rdChk(12'h270, 32'h0, "R1 period update");

    // R6 / R7 direct writes while stopped
    wr(12'h20C, 32'hABCD_0010);
    rdChk(12'h20C, 32'h0000_0010, "R6 period width");
    wr(12'h204, 32'hFFFF_0004);
    rdChk(12'h204, 32'h0000_0004, "R7 duty direct");
    wr(12'h200, 32'hFFFF_FFFF);
    rdChk(12'h200, 32'h0000_020F, "R6 mode readback");
    check(pwmOut[0] == 1'b1, "R5 stopped inverted", 32'(pwmOut[0]), 32'h1);
    wr(12'h200, 32'h0);
    check(pwmOut[0] == 1'b0, "R5 stopped normal", 32'(pwmOut[0]), 32'h0);

    // R2 enable and R4 waveform: period 16, duty 4 -> 12 active of 16
    wr(12'h004, 32'h1);
    rdChk(12'h00C, 32'h1, "R2 status one");
    highCount(0, 16, hc);
    check(hc == 12, "R4 active count", 32'(hc), 32'd12);

    // R7 direct write ignored while running
    wr(12'h204, 32'h8);
    rdChk(12'h204, 32'h4, "R7 duty ignored");

    // R8 buffered updates
    wr(12'h208, 32'h5555_0008);
    rdChk(12'h208, 32'h8, "R8 duty update readback");
    rdChk(12'h204, 32'(mDty[0]), "R8 duty held until wrap");
    repeat (20) @(negedge clk);
    rdChk(12'h204, 32'h8, "R8 duty applied");
    wr(12'h210, 32'd20);
    repeat (40) @(negedge clk);
    rdChk(12'h20C, 32'd20, "R8 period applied");
    highCount(0, 20, hc);
    check(hc == 12, "R8 new waveform", 32'(hc), 32'd12);

    // R3 prescaler: ch1 N=2 prd 4 dty 2; ch2 N=12 clamps to 10, prd 2 dty 1
    wr(12'h22C, 32'd4);
    wr(12'h224, 32'd2);
    wr(12'h220, 32'd2);
    wr(12'h24C, 32'd2);
    wr(12'h244, 32'd1);
    wr(12'h240, 32'd12);
    wr(12'h004, 32'h6);
    rdChk(12'h00C, 32'h7, "R2 status three");
    highCount(1, 64, hc);
    check(hc == 32, "R3 divide by 4", 32'(hc), 32'd32);
    highCount(2, 2048, hc);
    check(hc == 1024, "R3 clamp at 10", 32'(hc), 32'd1024);

    // R10 unmapped accesses
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h214, 32'h1234);
    wr(12'h280, 32'h55);
    rdChk(12'h100, 32'h0, "R10 unmapped low");
    rdChk(12'h214, 32'h0, "R10 bank hole");
    rdChk(12'h280, 32'h0, "R10 past last bank");
    rdChk(12'h004, 32'h0, "R10 enable reads zero");
    rdChk(12'h20C, 32'd20, "R10 period untouched");
    wr(12'h00C, 32'h0);
    rdChk(12'h00C, 32'h7, "R2 status read-only");

    // R9 disable and restart; R5 inverted running waveform
    wr(12'h008, 32'h1);
    check(pwmOut[0] == 1'b0, "R9 disabled inactive", 32'(pwmOut[0]), 32'h0);
    rdChk(12'h00C, 32'h6, "R9 status after disable");
    wr(12'h200, 32'h200);
    check(pwmOut[0] == 1'b1, "R5 disabled inverted", 32'(pwmOut[0]), 32'h1);
    wr(12'h004, 32'h1);
    highCount(0, 20, hc);
    check(hc == 8, "R5 inverted waveform", 32'(hc), 32'd8);

    // R4 zero period, R8 update through a bare tick
    wr(12'h26C, 32'd0);
    wr(12'h264, 32'd0);
    wr(12'h004, 32'h8);
    highCount(3, 10, hc);
    check(hc == 0, "R4 zero period inactive", 32'(hc), 32'd0);
    wr(12'h270, 32'd5);
    repeat (5) @(negedge clk);
    highCount(3, 10, hc);
    check(hc == 10, "R8 update from zero period", 32'(hc), 32'd10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule